// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable synchronous static memory with a registered read path and a two-bit burst counter. An access begins when one of two address strobes is seen on a rising clock edge. One strobe belongs to the processor side and always means a read. The other belongs to the controller side and carries either a read or a write, decided by the write controls. Once an access has started, an advance input steps through the three remaining words of an aligned group of four. A mode input picks linear or interleaved stepping. Bursts are optional, because a fresh address can be presented on every cycle.

The command is registered at the capture edge. The array is read or written at the next edge, so read data leaves the block one registered stage after its address was taken. Writes can use any mix of byte lanes, or all four lanes at once. The output drive turns off after a deselect with a delay of either one or two edges, chosen by a mode input. Output enable and the sleep input gate the drive without waiting for a clock. While sleep is high, new commands are refused and the stored words are kept.

Top module: `burst_sram`

## Requirements
- R1: While reset is high, and after it is released, the data outputs are not driven (dq_drive = 0) until a read has been registered.
- R2: Start decode. A processor strobe with chip_en = 1 starts a read. If both strobes are active, this read takes priority and nothing is written. A processor strobe with chip_en = 0 is ignored. A controller strobe with chip_en = 0 is a deselect.
- R3: The word address of beat k is {base[5:2], low}. With linear_mode = 1, low = base[1:0] + k mod 4. With linear_mode = 0, low = base[1:0] XOR k. After four beats, the fifth beat returns to the base address.
- R4: A read registered at edge N shows its word on dq_out after edge N+1. A new address can start on every cycle.
- R5: The write lane mask is 4'b1111 when glob_wr = 1, byte_sel when byte_en = 1, and zero otherwise. Lane i is din[9i+8:9i]. A controller strobe with a zero mask is a read. During a write burst, din and the mask are taken again on each advance edge.
- R6: With no strobe and adv = 0, the burst address and the pending operation stay unchanged. A held read keeps returning the same word.
- R7: With single_desel = 1, the drive turns off right after the edge that registers a deselect.
- R8: With single_desel = 0, the drive turns off only after the edge that follows the deselect edge.
- R9: oe = 0 forces dq_drive = 0 at once, without a clock edge.
- R10: While sleep = 1, the drive is off at once, strobes and advances are ignored, and the stored data is unchanged.
- R11: The stage that follows a write command does not drive the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Word address taken on a strobe |
| din | input | 36 | Write data, four 9-bit lanes |
| chip_en | input | 1 | Chip enable, active high |
| strobe_cpu | input | 1 | Processor-side start strobe (read) |
| strobe_ctl | input | 1 | Controller-side start strobe |
| adv | input | 1 | Burst advance |
| glob_wr | input | 1 | Write all lanes |
| byte_en | input | 1 | Enables byte_sel for a write |
| byte_sel | input | 4 | Per-lane write selects |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| single_desel | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power hold, acts asynchronously on the drive |
| dq_out | output | 36 | Read data |
| dq_drive | output | 1 | 1 when dq_out would be driven onto the bus |

## Verification
The bench builds the block with its defaults: 64 words of four 9-bit lanes. At that depth a full preload takes only a few dozen cycles, and random addresses often reuse a location and cross burst groups. Because the depth is small and each lane is narrow, a single byte-lane write shows up as a distinct value against its neighbours. It also lets both burst orders, every deselect mode and the strobe-priority cases be driven against the bench's word-level model in one short run.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              chip_en,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic              glob_wr,
  input  logic              byte_en,
  input  logic [BYTES-1:0]  byte_sel,
  input  logic              linear_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output op_e               op_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  wmask_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        low;
  logic [BYTES-1:0]  mask_in;
  logic start_rd, start_ctl, desel, step;

  always_comb begin
    start_rd  = strobe_cpu & chip_en;
    start_ctl = strobe_ctl & chip_en & ~start_rd;
    desel     = strobe_ctl & ~chip_en & ~start_rd;
    step      = ~start_rd & ~start_ctl & ~desel & adv & (op_q != OP_IDLE);
    mask_in   = glob_wr ? {BYTES{1'b1}} : (byte_en ? byte_sel : '0);
    low       = linear_mode ? (base_q[1:0] + beat_q) : (base_q[1:0] ^ beat_q);
    mem_addr  = {base_q[ADDR_W-1:2], low};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_IDLE;
      base_q  <= '0;
      beat_q  <= '0;
      wmask_q <= '0;
      wdata_q <= '0;
    end else if (!sleep) begin
      if (start_rd) begin
        op_q    <= OP_READ;
        base_q  <= addr;
        beat_q  <= '0;
        wmask_q <= '0;
      end else if (start_ctl) begin
        op_q    <= (|mask_in) ? OP_WRITE : OP_READ;
        base_q  <= addr;
        beat_q  <= '0;
        wmask_q <= mask_in;
        wdata_q <= din;
      end else if (desel) begin
        op_q    <= OP_IDLE;
        wmask_q <= '0;
      end else if (step) begin
        beat_q <= beat_q + 2'd1;
        if (op_q == OP_WRITE) begin
          wmask_q <= mask_in;
          wdata_q <= din;
        end
      end
    end
  end

  // R6: no strobe and no advance keeps burst position and operation
  a_r6_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu && !strobe_ctl && !adv) |=> ($stable(base_q) && $stable(beat_q) && $stable(op_q)));

  // R3: an advance from the last beat returns to the base address
  a_r3_wrap_return: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_cpu && !strobe_ctl && adv && op_q != OP_IDLE && beat_q == 2'd3)
      |=> (mem_addr == base_q || linear_mode != $past(linear_mode)));

  // R10: sleep freezes the command stage
  a_r10_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(op_q) && $stable(base_q) && $stable(beat_q) && $stable(wmask_q)));

  // R2: a processor strobe with chip enable low starts nothing
  a_r2_ce_low_ignored: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu && !chip_en && !strobe_ctl && !adv) |=> $stable(op_q));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [BYTES-1:0]  wmask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wmask[i]) mem[addr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/out_stage.sv
module out_stage
  import sram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op_q,
  input  logic single_desel,
  input  logic oe,
  input  logic sleep,
  output logic dq_drive
);
  logic drive_q;
  logic idle_now;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= (op_q == OP_READ);
  end

  always_comb begin
    idle_now = (op_q == OP_IDLE);
    dq_drive = oe & ~sleep & drive_q & ~(single_desel & idle_now);
  end

  // R9: output enable low means no drive
  a_r9_oe_off: assert property (@(posedge clk) disable iff (rst) !oe |-> !dq_drive);

  // R8: in dual mode, a deselect one edge back leaves no drive
  a_r8_dual_off: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_IDLE && !single_desel) |=> !dq_drive);

  // R11: a write command leaves the following stage undriven
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_WRITE) |=> !drive_q);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              chip_en,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic              glob_wr,
  input  logic              byte_en,
  input  logic [BYTES-1:0]  byte_sel,
  input  logic              linear_mode,
  input  logic              single_desel,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  op_e               op_q;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTES-1:0]  wmask_q;
  logic [DATA_W-1:0] wdata_q;

  burst_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .sleep(sleep), .chip_en(chip_en),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv),
    .glob_wr(glob_wr), .byte_en(byte_en), .byte_sel(byte_sel),
    .linear_mode(linear_mode), .addr(addr), .din(din),
    .op_q(op_q), .mem_addr(mem_addr), .wmask_q(wmask_q), .wdata_q(wdata_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we(op_q == OP_WRITE), .re(op_q == OP_READ),
    .wmask(wmask_q), .addr(mem_addr), .wdata(wdata_q), .rdata(dq_out)
  );

  out_stage u_out (
    .clk(clk), .rst(rst), .op_q(op_q), .single_desel(single_desel),
    .oe(oe), .sleep(sleep), .dq_drive(dq_drive)
  );

  // R10: sleep high means no drive
  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (rst) sleep |-> !dq_drive);

  // R7: single mode turns the drive off right after a deselect edge
  a_r7_single_off: assert property (@(posedge clk) disable iff (rst)
    (strobe_ctl && !chip_en && !sleep) |=> (!dq_drive || !single_desel));
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic chip_en = 1'b0, strobe_cpu = 1'b0, strobe_ctl = 1'b0, adv = 1'b0;
  logic glob_wr = 1'b0, byte_en = 1'b0;
  logic [3:0] byte_sel = '0;
  logic linear_mode = 1'b0, single_desel = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic dq_drive;

  int n_checks = 0, n_fail = 0, cycles = 0;

  burst_sram dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .chip_en(chip_en),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv),
    .glob_wr(glob_wr), .byte_en(byte_en), .byte_sel(byte_sel),
    .linear_mode(linear_mode), .single_desel(single_desel), .oe(oe),
    .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 idle, 1 read, 2 write
  logic [DW-1:0] m_mem [64];
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic [3:0]    m_mask = '0;
  logic [DW-1:0] m_wdata = '0;
  logic          m_drv = 1'b0;
  logic [DW-1:0] m_dout = '0;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] k, logic lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + k) : (b[1:0] ^ k);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [3:0] lane_mask(logic g, logic be, logic [3:0] bs);
    return g ? 4'b1111 : (be ? bs : 4'b0000);
  endfunction

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      m_op = 0; m_base = '0; m_beat = '0; m_mask = '0; m_drv = 1'b0;
    end else begin
      logic [AW-1:0] a;
      logic [3:0] mi;
      a = beat_addr(m_base, m_beat, linear_mode);
      m_drv = (m_op == 1);
      if (m_op == 1) m_dout = m_mem[a];
      if (m_op == 2)
        for (int i = 0; i < 4; i++)
          if (m_mask[i]) m_mem[a][i*9 +: 9] = m_wdata[i*9 +: 9];
      mi = lane_mask(glob_wr, byte_en, byte_sel);
      if (!sleep) begin
        if (strobe_cpu && chip_en) begin
          m_op = 1; m_base = addr; m_beat = 0; m_mask = 0;
        end else if (strobe_ctl && chip_en) begin
          m_op = (mi != 0) ? 2 : 1; m_base = addr; m_beat = 0; m_mask = mi; m_wdata = din;
        end else if (strobe_ctl && !chip_en) begin
          m_op = 0; m_mask = 0;
        end else if (adv && m_op != 0) begin
          m_beat = m_beat + 1;
          if (m_op == 2) begin m_mask = mi; m_wdata = din; end
        end
      end
    end
  end

  task automatic check_now(string tag);
    logic exp_drv;
    exp_drv = oe && !sleep && m_drv && !(single_desel && m_op == 0);
    n_checks++;
    if (dq_drive !== exp_drv) begin
      n_fail++;
      $display("FAIL %s drive: got %b expected %b", tag, dq_drive, exp_drv);
    end
    if (exp_drv) begin
      n_checks++;
      if (dq_out !== m_dout) begin
        n_fail++;
        $display("FAIL %s data: got %h expected %h", tag, dq_out, m_dout);
      end
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    check_now(tag);
  endtask

  task automatic idle_in();
    strobe_cpu = 0; strobe_ctl = 0; adv = 0; glob_wr = 0; byte_en = 0; byte_sel = 0;
  endtask

  task automatic cmd_read_cpu(logic [AW-1:0] a, string tag);
    idle_in(); chip_en = 1; strobe_cpu = 1; addr = a; step(tag);
  endtask

  task automatic cmd_read_ctl(logic [AW-1:0] a, string tag);
    idle_in(); chip_en = 1; strobe_ctl = 1; addr = a; step(tag);
  endtask

  task automatic cmd_write(logic [AW-1:0] a, logic [DW-1:0] d, logic g, logic [3:0] bs, string tag);
    idle_in(); chip_en = 1; strobe_ctl = 1; addr = a; din = d;
    glob_wr = g; byte_en = !g; byte_sel = bs; step(tag);
  endtask

  task automatic cmd_adv(string tag);
    idle_in(); adv = 1; step(tag);
  endtask

  task automatic cmd_hold(string tag);
    idle_in(); step(tag);
  endtask

  task automatic cmd_desel(string tag);
    idle_in(); chip_en = 0; strobe_ctl = 1; step(tag);
  endtask

  initial begin : wd
    while (cycles < 200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    cmd_hold("R1");
    // preload, R5 global write; R11 no drive after writes
    for (int a = 0; a < 64; a++) cmd_write(a[AW-1:0], {4{a[8:0] + 9'h0A5}}, 1, 0, "R11");
    cmd_hold("R11");
    // R4 back-to-back reads
    for (int a = 0; a < 10; a++) cmd_read_cpu(a[AW-1:0] * 6'd5, "R4");
    cmd_hold("R4");
    // R3 linear burst from a mid-group address, five beats
    linear_mode = 1;
    cmd_read_ctl(6'd13, "R3");
    for (int k = 0; k < 5; k++) cmd_adv("R3");
    // R3 interleaved
    linear_mode = 0;
    cmd_read_cpu(6'd22, "R3");
    for (int k = 0; k < 5; k++) cmd_adv("R3");
    // R6 hold between advances
    cmd_read_cpu(6'd41, "R6");
    cmd_hold("R6"); cmd_hold("R6"); cmd_adv("R6"); cmd_hold("R6"); cmd_hold("R6");
    // R5 byte-lane write then read back
    cmd_write(6'd9, 36'hFEDCBA987, 0, 4'b0101, "R5");
    cmd_write(6'd10, 36'h123456789, 0, 4'b0000, "R5");
    cmd_read_cpu(6'd9, "R5"); cmd_hold("R5"); cmd_hold("R5");
    // R5 write burst with changing lanes
    linear_mode = 1;
    cmd_write(6'd32, 36'h111111111, 1, 0, "R5");
    idle_in(); adv = 1; din = 36'h222222222; byte_en = 1; byte_sel = 4'b1000; step("R5");
    idle_in(); adv = 1; din = 36'h333333333; glob_wr = 1; step("R5");
    cmd_read_cpu(6'd32, "R5");
    for (int k = 0; k < 3; k++) cmd_adv("R5");
    cmd_hold("R5");
    // R2 both strobes: read wins, nothing written
    idle_in(); chip_en = 1; strobe_cpu = 1; strobe_ctl = 1; glob_wr = 1; addr = 6'd3;
    din = 36'h0DEADBEEF; step("R2");
    cmd_hold("R2"); cmd_read_cpu(6'd3, "R2"); cmd_hold("R2");
    // R2 processor strobe ignored with chip enable low
    idle_in(); chip_en = 0; strobe_cpu = 1; addr = 6'd60; step("R2");
    cmd_hold("R2"); cmd_hold("R2");
    // R7 single-cycle deselect
    single_desel = 1;
    cmd_read_cpu(6'd17, "R7"); cmd_hold("R7"); cmd_desel("R7"); cmd_hold("R7"); cmd_hold("R7");
    // R8 dual-cycle deselect
    single_desel = 0;
    cmd_read_cpu(6'd18, "R8"); cmd_hold("R8"); cmd_desel("R8"); cmd_hold("R8"); cmd_hold("R8");
    // R9 asynchronous output enable
    cmd_read_cpu(6'd19, "R9"); cmd_hold("R9");
    oe = 0; #1 check_now("R9");
    oe = 1; #1 check_now("R9");
    // R10 sleep refuses a write and keeps data
    sleep = 1; #1 check_now("R10");
    cmd_write(6'd19, 36'h0, 1, 0, "R10"); cmd_read_cpu(6'd5, "R10");
    sleep = 0; #1 check_now("R10");
    cmd_read_cpu(6'd19, "R10"); cmd_hold("R10"); cmd_hold("R10");
    // random traffic
    for (int n = 0; n < 2000; n++) begin
      int r;
      idle_in();
      r = $urandom_range(0, 99);
      chip_en = ($urandom_range(0, 9) != 0);
      addr = 6'($urandom); din = 36'({$urandom, $urandom});
      if (r < 25) strobe_cpu = 1;
      else if (r < 50) strobe_ctl = 1;
      else if (r < 80) adv = 1;
      glob_wr = ($urandom_range(0, 3) == 0);
      byte_en = $urandom_range(0, 1);
      byte_sel = 4'($urandom);
      if ($urandom_range(0, 19) == 0) linear_mode = ~linear_mode;
      if ($urandom_range(0, 29) == 0) single_desel = ~single_desel;
      oe = ($urandom_range(0, 15) != 0);
      sleep = ($urandom_range(0, 40) == 0);
      step("R4");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule